// File: doc/BRIEF.md
# Brown-out Reset Filter Controller

This block is the digital half of a programmable supply-drop detector. An analog comparator reports whether the supply is below a selected threshold. The block synchronises that flag and filters it. It raises a chip-wide reset request only after the low condition has persisted for a fixed time. It holds the request while the supply stays low. It drops the request, with a one-cycle full-restart pulse, only after the supply has stayed good for the same persistence time. Any change of the comparator before the window completes restarts the timer.

A small configuration word is captured while the block's own reset input is high. It supplies an enable bit and one of three detection levels. The block drives a threshold-select code back to the comparator. The low two bits of that code carry the level. The top bit chooses the higher, rising threshold while reset is being requested and the lower, falling threshold otherwise, which gives the comparator hysteresis. While the chip is in halt mode the detector is forced inactive. The block is cleared only by its own reset input, which comes from the power-on detector, and never by the reset request it drives.

Top module: `brownout_filter`

## Requirements
- R1: The enable bit (cfg_i[0]) and the level field (cfg_i[2:1]) are captured on every clock edge while rst is high. Changes on cfg_i while rst is low have no effect on any output.
- R2: When enabled, with halt_i low and no reset requested, rst_req_o rises exactly SYNC_STAGES + PERSIST_CYC clock edges after cmp_low_i goes high and stays high.
- R3: A high level on cmp_low_i that lasts PERSIST_CYC-1 cycles or less, starting from the idle state, leaves rst_req_o low, and the timer starts again from zero.
- R4: thr_sel_o[1:0] is the captured level, with 00 = lowest, 01 = middle, 10 = highest, and 11 mapped to 00. thr_sel_o[2] is 1 (rising threshold) exactly while rst_req_o is 1, and 0 (falling threshold) otherwise.
- R5: Once asserted, rst_req_o stays high while cmp_low_i stays high. A low-going gap on cmp_low_i of PERSIST_CYC-1 cycles or less does not release it.
- R6: When cmp_low_i has been low for a full window, rst_req_o falls SYNC_STAGES + PERSIST_CYC edges after cmp_low_i went low. restart_o is high for exactly that one cycle, and never at any other time.
- R7: A clock edge that sees halt_i high forces rst_req_o low after that edge, with no restart_o pulse, and clears the timer. This holds even on the edge where a window would have completed. After halt_i falls, a full fresh window is needed.
- R8: With the captured enable bit at 0, rst_req_o never rises, whatever cmp_low_i does.
- R9: The captured configuration and the filter state are cleared only by rst. While rst_req_o is high, thr_sel_o[1:0] keeps the level and the release path still works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset from the power-on detector; also captures cfg_i |
| cfg_i | input | 3 | Configuration: bit 0 enable, bits 2:1 level |
| halt_i | input | 1 | High while the chip is in halt mode |
| cmp_low_i | input | 1 | Comparator output, high when supply is below the selected threshold |
| thr_sel_o | output | 3 | Threshold select to comparator: bit 2 rising/falling, bits 1:0 level |
| rst_req_o | output | 1 | Reset request to the rest of the chip |
| restart_o | output | 1 | One-cycle pulse on release, requesting a restart from the program start |

## Verification
Halt and the completion of a persistence window can fall on the same clock edge, and the two disagree about whether reset should rise. The bench holds the comparator low and raises halt so that it is first seen on exactly the edge where the count would finish. The scoreboard then expects no reset event at all. Once halt drops, it expects an assertion only a complete fresh window later, which shows that halt both won the tie and cleared the partial count.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic {
    ST_GUARD = 1'b0,
    ST_HOLD  = 1'b1
  } bf_state_e;

  typedef struct packed {
    logic       en;
    logic [1:0] lvl;
  } bf_cfg_t;

  localparam int CFG_W       = 3;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LVL_LSB = 1;

  // Reserved level code 11 falls back to the lowest level.
  function automatic logic [1:0] bf_norm_level(input logic [1:0] raw);
    return (raw == 2'b11) ? 2'b00 : raw;
  endfunction

endpackage

// File: rtl/bf_cfg_latch.sv
module bf_cfg_latch
  import bf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  output bf_cfg_t          cfg_o
);

  bf_cfg_t cfg_q;

  // Sampled only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.en  <= cfg_i[CFG_EN_BIT];
      cfg_q.lvl <= bf_norm_level(cfg_i[CFG_LVL_LSB +: 2]);
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/bf_sync.sv
module bf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic d_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign d_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bf_persist_timer.sv
module bf_persist_timer #(
  parameter int PERSIST_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic done_o
);

  localparam int CNT_W = (PERSIST_CYC > 1) ? $clog2(PERSIST_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // done_o fires on the PERSIST_CYC-th consecutive edge with cond_i high.
  assign done_o = cond_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !cond_i || done_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bf_reset_fsm.sv
module bf_reset_fsm
  import bf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic done_i,
  output logic hold_o,
  output logic restart_o
);

  bf_state_e st_q, st_d;
  logic      restart_q, restart_d;

  always_comb begin
    st_d      = st_q;
    restart_d = 1'b0;
    if (!active_i) begin
      st_d = ST_GUARD;                 // halt or disabled: no request, no restart
    end else if (done_i) begin
      if (st_q == ST_GUARD) begin
        st_d = ST_HOLD;
      end else begin
        st_d      = ST_GUARD;
        restart_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_GUARD;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      restart_q <= restart_d;
    end
  end

  assign hold_o    = (st_q == ST_HOLD);
  assign restart_o = restart_q;

endmodule

// File: rtl/brownout_filter.sv
module brownout_filter
  import bf_pkg::*;
#(
  parameter int CLK_HZ      = 10_000_000,
  parameter int PERSIST_NS  = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             halt_i,
  input  logic             cmp_low_i,
  output logic [2:0]       thr_sel_o,
  output logic             rst_req_o,
  output logic             restart_o
);

  localparam longint CYC_RAW     = (longint'(CLK_HZ) / 1000 * longint'(PERSIST_NS)) / 1_000_000;
  localparam int     PERSIST_CYC = (CYC_RAW < 1) ? 1 : int'(CYC_RAW);

  bf_cfg_t cfg_q;
  logic    cfg_en;
  logic    cmp_s;
  logic    active;
  logic    hold;
  logic    cond;
  logic    done;

  bf_cfg_latch u_cfg (
    .clk   (clk),
    .rst   (rst),
    .cfg_i (cfg_i),
    .cfg_o (cfg_q)
  );

  assign cfg_en = cfg_q.en;

  bf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_low_i),
    .d_o (cmp_s)
  );

  assign active = cfg_en && !halt_i;
  // Count toward the opposite state: low supply while idle, good supply while holding.
  assign cond   = active && (cmp_s != hold);

  bf_persist_timer #(.PERSIST_CYC(PERSIST_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .cond_i (cond),
    .done_o (done)
  );

  bf_reset_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .done_i    (done),
    .hold_o    (hold),
    .restart_o (restart_o)
  );

  assign rst_req_o = hold;
  assign thr_sel_o = {hold, cfg_q.lvl};

endmodule

// File: rtl/bf_checker.sv
module bf_checker #(
  parameter int PERSIST_CYC = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       halt_i,
  input logic       cmp_s,
  input logic       cfg_en,
  input logic [2:0] thr_sel_o,
  input logic       rst_req_o,
  input logic       restart_o
);

  localparam int RW = $clog2(PERSIST_CYC + 1) + 1;
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic          armed_q;
  logic [RW-1:0] hi_run_q, lo_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      armed_q  <= 1'b1;
      hi_run_q <= (cfg_en && !halt_i && cmp_s && !rst_req_o)
                  ? ((hi_run_q == RMAX) ? hi_run_q : hi_run_q + 1'b1) : '0;
      lo_run_q <= (cfg_en && !halt_i && !cmp_s && rst_req_o)
                  ? ((lo_run_q == RMAX) ? lo_run_q : lo_run_q + 1'b1) : '0;
    end
  end

  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> $stable(thr_sel_o[1:0]));

  p_assert_window_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> (hi_run_q >= RW'(PERSIST_CYC)));

  p_level_legal_r4: assert property (@(posedge clk) disable iff (rst)
    thr_sel_o[1:0] != 2'b11);

  p_hold_while_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && cmp_s && cfg_en && !halt_i) |=> rst_req_o);

  p_release_window_r6: assert property (@(posedge clk) disable iff (rst)
    (restart_o && $fell(rst_req_o)) |-> (lo_run_q >= RW'(PERSIST_CYC)));

  p_restart_only_on_release_r6: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> $fell(rst_req_o));

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (!rst_req_o && !restart_o));

  p_disabled_silent_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> !rst_req_o);

endmodule

bind brownout_filter bf_checker #(.PERSIST_CYC(PERSIST_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .halt_i    (halt_i),
  .cmp_s     (cmp_s),
  .cfg_en    (cfg_en),
  .thr_sel_o (thr_sel_o),
  .rst_req_o (rst_req_o),
  .restart_o (restart_o)
);

// File: tb/brownout_filter_tb_top.sv
module brownout_filter_tb_top;

  localparam int P = 500;   // 5 us at 100 MHz
  localparam int S = 2;

  typedef struct {
    int    cyc;
    int    kind;   // 0 assert, 1 release with restart, 2 quiet release
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_i = 3'b000;
  logic       halt_i = 1'b0;
  logic       cmp_low_i = 1'b0;
  logic [2:0] thr_sel_o;
  logic       rst_req_o;
  logic       restart_o;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  prev_req = 1'b0;
  bit  done = 1'b0;
  ev_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brownout_filter #(.CLK_HZ(100_000_000), .PERSIST_NS(5000), .SYNC_STAGES(S)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_i     (cfg_i),
    .halt_i    (halt_i),
    .cmp_low_i (cmp_low_i),
    .thr_sel_o (thr_sel_o),
    .rst_req_o (rst_req_o),
    .restart_o (restart_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push(int c, int k, string r);
    ev_t e;
    e.cyc = c; e.kind = k; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [2:0] cfg);
    @(negedge clk);
    rst = 1'b1; cfg_i = cfg; cmp_low_i = 1'b0; halt_i = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  // Monitor: every edge of rst_req_o is popped against the scoreboard.
  always @(negedge clk) begin
    if (rst) begin
      prev_req = rst_req_o;
    end else begin
      if (rst_req_o !== prev_req) begin
        int kind;
        kind = rst_req_o ? 0 : (restart_o ? 1 : 2);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R6/R7", "unexpected reset event kind", kind, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, e.req, "event cycle", cyc, e.cyc);
          chk(kind == e.kind, e.req, "event kind", kind, e.kind);
        end
      end else if (restart_o) begin
        chk(1'b0, "R6", "restart pulse without release", 1, 0);
      end
      prev_req = rst_req_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 200000);
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    do_reset(3'b011);                      // enable, level 01
    chk(rst_req_o == 1'b0, "R2", "reset-state request", rst_req_o, 0);
    chk(restart_o == 1'b0, "R6", "reset-state restart", restart_o, 0);
    chk(thr_sel_o == 3'b001, "R4", "reset-state select", thr_sel_o, 3'b001);

    cfg_i = 3'b100;                        // would disable and pick level 10
    wait_n(3);
    chk(thr_sel_o == 3'b001, "R1", "select after cfg change", thr_sel_o, 3'b001);

    // R3: low pulse one cycle short of the window
    cmp_low_i = 1'b1; wait_n(P - 1); cmp_low_i = 1'b0;
    wait_n(P + 20);
    chk(rst_req_o == 1'b0, "R3", "short low pulse", rst_req_o, 0);

    // R2: sustained low (also shows captured enable survives cfg change, R1)
    c = cyc; cmp_low_i = 1'b1; push(c + S + P, 0, "R2");
    wait_n(S + P + 5);
    chk(rst_req_o == 1'b1, "R2", "request after window", rst_req_o, 1);
    chk(thr_sel_o == 3'b101, "R4", "rising select while held", thr_sel_o, 3'b101);

    // R5: short good-supply gap
    cmp_low_i = 1'b0; wait_n(P - 1); cmp_low_i = 1'b1;
    wait_n(P + 20);
    chk(rst_req_o == 1'b1, "R5", "held through short gap", rst_req_o, 1);
    chk(thr_sel_o[1:0] == 2'b01, "R9", "level kept while held", thr_sel_o[1:0], 1);

    // R6: release with restart pulse
    c = cyc; cmp_low_i = 1'b0; push(c + S + P, 1, "R6");
    wait_n(S + P + 2);
    chk(restart_o == 1'b0, "R6", "restart is one cycle", restart_o, 0);
    chk(thr_sel_o == 3'b001, "R4", "falling select after release", thr_sel_o, 3'b001);

    // R7: halt seen on the completing edge
    c = cyc; cmp_low_i = 1'b1;
    wait_n(P + 1);
    halt_i = 1'b1;
    wait_n(50);
    chk(rst_req_o == 1'b0, "R7", "halt wins on completing edge", rst_req_o, 0);
    c = cyc; halt_i = 1'b0; push(c + P, 0, "R7");
    wait_n(P + 5);
    chk(rst_req_o == 1'b1, "R7", "fresh window after halt", rst_req_o, 1);

    // R7: halt while held
    c = cyc; halt_i = 1'b1; push(c + 1, 2, "R7");
    wait_n(10);
    chk(rst_req_o == 1'b0, "R7", "halt drops request", rst_req_o, 0);
    c = cyc; halt_i = 1'b0; push(c + P, 0, "R7");
    wait_n(P + 5);
    c = cyc; cmp_low_i = 1'b0; push(c + S + P, 1, "R6");
    wait_n(S + P + 5);
    chk(exp_q.size() == 0, "R6", "all events seen", exp_q.size(), 0);

    // R8: disabled, reserved level
    do_reset(3'b110);
    chk(thr_sel_o == 3'b000, "R4", "reserved level maps low", thr_sel_o, 3'b000);
    cmp_low_i = 1'b1; wait_n(2 * P);
    chk(rst_req_o == 1'b0, "R8", "disabled never asserts", rst_req_o, 0);
    cmp_low_i = 1'b0; wait_n(5);

    // R4: highest level
    do_reset(3'b101);
    chk(thr_sel_o == 3'b010, "R4", "highest level select", thr_sel_o, 3'b010);
    c = cyc; cmp_low_i = 1'b1; push(c + S + P, 0, "R2");
    wait_n(S + P + 5);
    chk(thr_sel_o == 3'b110, "R4", "highest rising select", thr_sel_o, 3'b110);
    c = cyc; cmp_low_i = 1'b0; push(c + S + P, 1, "R6");
    wait_n(S + P + 5);
    chk(exp_q.size() == 0, "R6", "queue drained", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule